// File: doc/BRIEF.md
# Prefetching Bus Access Sequencer

This block orders and times the memory bus cycles of a small word-addressed processor that fetches one instruction ahead. It takes a stream of already-decoded instruction descriptors through a valid/ready handshake. Each descriptor gives the following:

- the count of extension words;
- the destination mode (register, indexed or autoincrement);
- a byte/word flag;
- a branch flag and its outcome;
- the register value, the displacement value and the branch target that the bus addresses are derived from.

For each instruction the sequencer issues opcode fetches, extension-word reads and destination read-modify-write cycles. Each bus cycle occupies a fixed number of clocks. No data-path arithmetic, no decoding and no asynchronous handshake take place here, and every reply arrives without wait states.

Two orderings set this block apart from a plain in-order sequencer. The memory update of an autoincrement destination is held back. It runs after the following opcode has been fetched and before that instruction's extension words. A branch always fetches the next sequential opcode. If the branch is taken, that fetch is reported as discarded and fetching resumes at the target. If it is not taken, the fetched opcode is kept and the following instruction does not fetch it again.

Every finished bus cycle produces a one-clock completion pulse together with its kind, address and byte flag. A running total of bus clocks is also kept.

Top module: `prefetch_bus_seq`

## Requirements
- R1: An opcode fetch reports kind 0, lasts 8 clocks and uses the current instruction address. The next instruction's address is the current address plus 2 plus 2 per extension word, except after a branch.
- R2: Extension words are read in order at the addresses directly after the opcode. Each read has kind 1 and lasts 12 clocks, and all of them come after any deferred update and before the instruction's own indexed update.
- R3: An indexed destination (mode 1) is updated by one read-modify-write cycle of kind 2. It lasts 16 clocks and follows the extension words, at address displacement plus register value (mod 2^16).
- R4: An autoincrement destination (mode 2) is not updated during its own instruction. Its kind-2 cycle lasts 18 clocks, uses the register value from before the increment, and is issued right after the next opcode fetch. With it the block reports the incremented register value: plus 1 for a byte operation, plus 2 for a word operation.
- R5: At most one deferred update is pending at any time, and a pending update is always completed before a new one is recorded.
- R6: A branch is followed by an 8-clock fetch at the address after the branch. If the branch is taken, this fetch reports kind 3 (discarded) and the next instruction is fetched at the target. If it is not taken, the fetch reports kind 0 and the next instruction issues no opcode fetch of its own.
- R7: The byte strobe is high only on completion of a read-modify-write cycle that belongs to a byte operation. In that case address bit 0 selects the byte: 0 for the low byte, 1 for the high byte.
- R8: The bus-active output is high for exactly the cost of each bus cycle, ending on its completion pulse. The clock total grows by that cost, and the new total is visible one clock after the pulse.
- R9: After reset the block is ready, idle, shows a zero total and fetches first at the reset address. A descriptor is accepted only while no instruction is in progress.
- R10: A loop made of an indexed byte clear, an autoincrement byte clear, a test with one immediate word and a taken branch costs 98 bus clocks per iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be accepted |
| in_next | input | 2 | Number of extension words (0 to 2) |
| in_mode | input | 2 | Destination mode: 0 register, 1 indexed, 2 autoincrement |
| in_byte | input | 1 | Byte operation |
| in_branch | input | 1 | Instruction is a branch |
| in_taken | input | 1 | Branch outcome |
| in_rval | input | 16 | Destination register value |
| in_disp | input | 16 | Index displacement value |
| in_target | input | 16 | Branch target address |
| bus_act | output | 1 | A bus cycle is in progress |
| cyc_done | output | 1 | Bus cycle completes this clock |
| cyc_kind | output | 2 | 0 opcode, 1 extension, 2 read-modify-write, 3 discarded |
| cyc_addr | output | 16 | Address of the completing cycle |
| cyc_byte | output | 1 | Byte strobe of the completing cycle |
| cyc_upd_vld | output | 1 | Incremented register value is reported |
| cyc_upd_val | output | 16 | Incremented register value |
| clk_total | output | 32 | Running bus clock total |

## Verification
A wrong ordering state, such as a lost or duplicated deferred update or a stale prefetch flag, shows up on the first completion pulse after the instruction that follows. That pulse then carries the wrong kind or address, or arrives where none is expected. A wrong cycle length appears within that same bus cycle as a mismatch between the bus-active run and the cost, and one clock later as a wrong running total. The sweep runs every pair of instruction shapes from reset and appends a draining instruction, so every transition between a pending update, a kept prefetch and a discarded prefetch is reached.

// File: rtl/pfseq_pkg.sv
package pfseq_pkg;

    localparam int AW = 16;

    typedef enum logic [1:0] {
        K_OPC  = 2'd0,
        K_EXT  = 2'd1,
        K_RMW  = 2'd2,
        K_DISC = 2'd3
    } kind_e;

    localparam logic [1:0] M_REG  = 2'd0;
    localparam logic [1:0] M_IDX  = 2'd1;
    localparam logic [1:0] M_AINC = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_DEF,
        ST_EXT,
        ST_RMW,
        ST_SPEC
    } step_e;

    typedef struct packed {
        logic [1:0]    n_ext;
        logic [1:0]    mode;
        logic          is_byte;
        logic          is_br;
        logic          taken;
        logic [AW-1:0] rval;
        logic [AW-1:0] disp;
        logic [AW-1:0] target;
    } desc_t;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          is_byte;
        logic [AW-1:0] upd;
    } pend_t;

    function automatic logic [AW-1:0] inc_of(input logic is_byte);
        return is_byte ? AW'(1) : AW'(2);
    endfunction

endpackage

// File: rtl/pfseq_timer.sv
module pfseq_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] cost,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= cost;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R8: a cycle is never started over a running one and never with zero length
    a_r8_load_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> (!busy && cost != '0));
    // R8: once started, the count runs down without stalling
    a_r8_countdown: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: rtl/pfseq_defer.sv
module pfseq_defer
    import pfseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          put,
    input  logic [AW-1:0] put_addr,
    input  logic          put_byte,
    input  logic [AW-1:0] put_upd,
    input  logic          take,
    output pend_t         slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (put) begin
            slot.vld     <= 1'b1;
            slot.addr    <= put_addr;
            slot.is_byte <= put_byte;
            slot.upd     <= put_upd;
        end else if (take) begin
            slot.vld <= 1'b0;
        end
    end

    // R5: a new deferred update never lands on an unfinished one
    a_r5_single_pending: assert property (@(posedge clk) disable iff (rst)
        put |-> !slot.vld);
    // R5: only a recorded update can be retired
    a_r5_take_valid: assert property (@(posedge clk) disable iff (rst)
        take |-> slot.vld);
endmodule

// File: rtl/pfseq_tally.sv
module pfseq_tally #(
    parameter int TW = 32,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add,
    input  logic [CW-1:0] amount,
    output logic [TW-1:0] total
);
    always_ff @(posedge clk) begin
        if (rst)
            total <= '0;
        else if (add)
            total <= total + TW'(amount);
    end

    // R8: the total only moves on a completed bus cycle
    a_r8_total_hold: assert property (@(posedge clk) disable iff (rst)
        !add |=> $stable(total));
endmodule

// File: rtl/prefetch_bus_seq.sv
module prefetch_bus_seq
    import pfseq_pkg::*;
#(
    parameter int            C_OPC    = 8,
    parameter int            C_EXT    = 12,
    parameter int            C_RMWX   = 16,
    parameter int            C_RMWD   = 18,
    parameter int            TW       = 32,
    parameter logic [AW-1:0] RESET_PC = 16'h0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_next,
    input  logic [1:0]    in_mode,
    input  logic          in_byte,
    input  logic          in_branch,
    input  logic          in_taken,
    input  logic [AW-1:0] in_rval,
    input  logic [AW-1:0] in_disp,
    input  logic [AW-1:0] in_target,
    output logic          bus_act,
    output logic          cyc_done,
    output logic [1:0]    cyc_kind,
    output logic [AW-1:0] cyc_addr,
    output logic          cyc_byte,
    output logic          cyc_upd_vld,
    output logic [AW-1:0] cyc_upd_val,
    output logic [TW-1:0] clk_total
);
    localparam int CMAX1 = (C_OPC > C_EXT) ? C_OPC : C_EXT;
    localparam int CMAX2 = (C_RMWX > C_RMWD) ? C_RMWX : C_RMWD;
    localparam int CMAX  = (CMAX1 > CMAX2) ? CMAX1 : CMAX2;
    localparam int CW    = $clog2(CMAX + 1);
    localparam logic [AW-1:0] WSTEP = AW'(2);

    step_e         st, st_n;
    desc_t         d;
    logic [AW-1:0] pc, ext_addr;
    logic [1:0]    ext_left;
    logic          skip_opc;
    kind_e         cur_kind, last_kind;
    logic [AW-1:0] cur_addr, cur_upd;
    logic          cur_byte, cur_updv;
    logic [CW-1:0] cur_cost;

    logic          load, tbusy, tdone;
    logic [CW-1:0] ld_cost;
    kind_e         ld_kind;
    logic [AW-1:0] ld_addr, ld_upd;
    logic          ld_byte, ld_updv;
    logic          put, take, adv_ext, fin, accept;
    pend_t         pend;

    assign in_ready = (st == ST_IDLE);
    assign accept   = in_valid && in_ready;

    pfseq_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .cost (ld_cost),
        .busy (tbusy),
        .done (tdone)
    );

    pfseq_defer u_defer (
        .clk      (clk),
        .rst      (rst),
        .put      (put),
        .put_addr (d.rval),
        .put_byte (d.is_byte),
        .put_upd  (d.rval + inc_of(d.is_byte)),
        .take     (take),
        .slot     (pend)
    );

    pfseq_tally #(.TW(TW), .CW(CW)) u_tally (
        .clk    (clk),
        .rst    (rst),
        .add    (tdone),
        .amount (cur_cost),
        .total  (clk_total)
    );

    // Step selection: each step either launches one bus cycle or passes on
    always_comb begin
        load    = 1'b0;
        ld_cost = '0;
        ld_kind = K_OPC;
        ld_addr = pc;
        ld_byte = 1'b0;
        ld_updv = 1'b0;
        ld_upd  = '0;
        st_n    = st;
        put     = 1'b0;
        take    = 1'b0;
        adv_ext = 1'b0;
        fin     = 1'b0;
        case (st)
            ST_IDLE: begin
                if (in_valid) st_n = ST_OPC;
            end
            ST_OPC: begin
                if (tdone) begin
                    st_n = ST_DEF;
                end else if (!tbusy) begin
                    if (!skip_opc) begin
                        load    = 1'b1;
                        ld_cost = CW'(C_OPC);
                        ld_kind = K_OPC;
                        ld_addr = pc;
                    end else begin
                        st_n = ST_DEF;
                    end
                end
            end
            ST_DEF: begin
                if (tdone) begin
                    take = 1'b1;
                    st_n = ST_EXT;
                end else if (!tbusy) begin
                    if (pend.vld) begin
                        load    = 1'b1;
                        ld_cost = CW'(C_RMWD);
                        ld_kind = K_RMW;
                        ld_addr = pend.addr;
                        ld_byte = pend.is_byte;
                        ld_updv = 1'b1;
                        ld_upd  = pend.upd;
                    end else begin
                        st_n = ST_EXT;
                    end
                end
            end
            ST_EXT: begin
                if (tdone) begin
                    adv_ext = 1'b1;
                end else if (!tbusy) begin
                    if (ext_left != 2'd0) begin
                        load    = 1'b1;
                        ld_cost = CW'(C_EXT);
                        ld_kind = K_EXT;
                        ld_addr = ext_addr;
                    end else begin
                        st_n = ST_RMW;
                    end
                end
            end
            ST_RMW: begin
                if (tdone) begin
                    st_n = ST_SPEC;
                end else if (!tbusy) begin
                    if (d.mode == M_IDX) begin
                        load    = 1'b1;
                        ld_cost = CW'(C_RMWX);
                        ld_kind = K_RMW;
                        ld_addr = d.disp + d.rval;
                        ld_byte = d.is_byte;
                    end else begin
                        put  = (d.mode == M_AINC);
                        st_n = ST_SPEC;
                    end
                end
            end
            ST_SPEC: begin
                if (tdone) begin
                    fin  = 1'b1;
                    st_n = ST_IDLE;
                end else if (!tbusy) begin
                    if (d.is_br) begin
                        load    = 1'b1;
                        ld_cost = CW'(C_OPC);
                        ld_kind = d.taken ? K_DISC : K_OPC;
                        ld_addr = ext_addr;
                    end else begin
                        fin  = 1'b1;
                        st_n = ST_IDLE;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            d         <= '0;
            pc        <= RESET_PC;
            ext_addr  <= '0;
            ext_left  <= '0;
            skip_opc  <= 1'b0;
            cur_kind  <= K_OPC;
            cur_addr  <= '0;
            cur_byte  <= 1'b0;
            cur_updv  <= 1'b0;
            cur_upd   <= '0;
            cur_cost  <= '0;
            last_kind <= K_RMW;
        end else begin
            st <= st_n;
            if (accept) begin
                d.n_ext   <= in_next;
                d.mode    <= in_mode;
                d.is_byte <= in_byte;
                d.is_br   <= in_branch;
                d.taken   <= in_taken;
                d.rval    <= in_rval;
                d.disp    <= in_disp;
                d.target  <= in_target;
                ext_addr  <= pc + WSTEP;
                ext_left  <= in_next;
            end
            if (adv_ext) begin
                ext_addr <= ext_addr + WSTEP;
                ext_left <= ext_left - 2'd1;
            end
            if (load) begin
                cur_kind <= ld_kind;
                cur_addr <= ld_addr;
                cur_byte <= ld_byte;
                cur_updv <= ld_updv;
                cur_upd  <= ld_upd;
                cur_cost <= ld_cost;
            end
            if (tdone)
                last_kind <= cur_kind;
            if (fin) begin
                pc       <= (d.is_br && d.taken) ? d.target : ext_addr;
                skip_opc <= d.is_br && !d.taken;
            end
        end
    end

    assign bus_act     = tbusy;
    assign cyc_done    = tdone;
    assign cyc_kind    = cur_kind;
    assign cyc_addr    = cur_addr;
    assign cyc_byte    = tdone && cur_byte;
    assign cyc_upd_vld = tdone && cur_updv;
    assign cyc_upd_val = cur_upd;

    // R4: a deferred update always comes straight after an opcode fetch
    a_r4_def_after_opc: assert property (@(posedge clk) disable iff (rst)
        (tdone && cur_updv) |-> (last_kind == K_OPC));
    // R7: byte strobe only on read-modify-write completions
    a_r7_byte_rmw: assert property (@(posedge clk) disable iff (rst)
        cyc_byte |-> (cyc_kind == K_RMW));
    // R9: a descriptor is taken only with the bus quiet
    a_r9_accept_quiet: assert property (@(posedge clk) disable iff (rst)
        accept |-> !tbusy);
    // R2: extension reads never exceed the descriptor count
    a_r2_ext_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXT) |-> (ext_left <= d.n_ext));
endmodule

// File: tb/tb_prefetch_bus_seq.sv
module tb_prefetch_bus_seq;
    localparam logic [15:0] START = 16'h0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_next = '0;
    logic [1:0]  in_mode = '0;
    logic        in_byte = 1'b0;
    logic        in_branch = 1'b0;
    logic        in_taken = 1'b0;
    logic [15:0] in_rval = '0, in_disp = '0, in_target = '0;
    logic        bus_act, cyc_done, cyc_byte, cyc_upd_vld;
    logic [1:0]  cyc_kind;
    logic [15:0] cyc_addr, cyc_upd_val;
    logic [31:0] clk_total;

    prefetch_bus_seq #(.RESET_PC(START)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_next(in_next), .in_mode(in_mode), .in_byte(in_byte),
        .in_branch(in_branch), .in_taken(in_taken), .in_rval(in_rval),
        .in_disp(in_disp), .in_target(in_target), .bus_act(bus_act),
        .cyc_done(cyc_done), .cyc_kind(cyc_kind), .cyc_addr(cyc_addr),
        .cyc_byte(cyc_byte), .cyc_upd_vld(cyc_upd_vld),
        .cyc_upd_val(cyc_upd_val), .clk_total(clk_total)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected event queue
    int e_kind [0:255];
    int e_addr [0:255];
    int e_cost [0:255];
    bit e_byte [0:255];
    bit e_uv   [0:255];
    int e_uval [0:255];
    int wr = 0;
    int rd = 0;

    task automatic push(input int k, input int a, input int c, input bit b,
                        input bit uv, input int uval);
        e_kind[wr[7:0]] = k; e_addr[wr[7:0]] = a & 16'hFFFF; e_cost[wr[7:0]] = c;
        e_byte[wr[7:0]] = b; e_uv[wr[7:0]] = uv; e_uval[wr[7:0]] = uval & 16'hFFFF;
        wr++;
    endtask

    // reference ordering model
    int m_pc; bit m_skip; bit m_pv; int m_pa; bit m_pb; int m_pu;

    task automatic model(input int n, input int mode, input bit byt, input bit br,
                         input bit tk, input int rval, input int disp, input int tgt);
        int a;
        int nx;
        a = m_pc;
        if (!m_skip) push(0, a, 8, 0, 0, 0);
        if (m_pv) begin
            push(2, m_pa, 18, m_pb, 1, m_pu);
            m_pv = 0;
        end
        for (int k = 0; k < n; k++) push(1, a + 2 + 2*k, 12, 0, 0, 0);
        if (mode == 1) push(2, disp + rval, 16, byt, 0, 0);
        if (mode == 2) begin
            m_pv = 1; m_pa = rval; m_pb = byt; m_pu = rval + (byt ? 1 : 2);
        end
        nx = (a + 2 + 2*n) & 16'hFFFF;
        if (br) begin
            push(tk ? 3 : 0, nx, 8, 0, 0, 0);
            m_pc = tk ? tgt : nx;
            m_skip = !tk;
        end else begin
            m_pc = nx;
            m_skip = 0;
        end
    endtask

    task automatic send(input int n, input int mode, input bit byt, input bit br,
                        input bit tk, input int rval, input int disp, input int tgt);
        model(n, mode, byt, br, tk, rval, disp, tgt);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_next = n[1:0]; in_mode = mode[1:0]; in_byte = byt;
        in_branch = br; in_taken = tk; in_rval = rval[15:0];
        in_disp = disp[15:0]; in_target = tgt[15:0];
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (rd != wr || !in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    int exp_total = 0;
    int run = 0;
    bit chk_tot = 0;

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = START; m_skip = 0; m_pv = 0;
        rd = 0; wr = 0; exp_total = 0; run = 0; chk_tot = 0;
        @(negedge clk);
        // R9: reset state
        chk(in_ready && !cyc_done && !bus_act && clk_total == 0, "R9 reset state",
            {in_ready, cyc_done, bus_act}, 3'b100);
    endtask

    // monitor: compares each completion with the model
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_act) run++;
            if (cyc_done) begin
                if (rd == wr) begin
                    chk(0, "R1 unexpected bus cycle", cyc_addr, 0);
                end else begin
                    int i;
                    string tg;
                    i = rd % 256;
                    case (e_kind[i])
                        0: tg = "R1 opcode fetch";
                        1: tg = "R2 extension read";
                        2: tg = e_uv[i] ? "R4 deferred update" : "R3 indexed update";
                        default: tg = "R6 discarded fetch";
                    endcase
                    chk(cyc_kind == e_kind[i], {tg, " kind"}, cyc_kind, e_kind[i]);
                    chk(cyc_addr == e_addr[i], {tg, " address"}, cyc_addr, e_addr[i]);
                    chk(cyc_byte == e_byte[i], "R7 byte strobe", cyc_byte, e_byte[i]);
                    chk(cyc_upd_vld == e_uv[i] && (!e_uv[i] || cyc_upd_val == e_uval[i]),
                        "R4 incremented value", cyc_upd_val, e_uval[i]);
                    chk(run == e_cost[i], "R8 bus active length", run, e_cost[i]);
                    exp_total += e_cost[i];
                    rd++;
                end
                run = 0;
                chk_tot = 1;
            end else if (chk_tot) begin
                chk(clk_total == exp_total, "R8 clock total", clk_total, exp_total);
                chk_tot = 0;
            end
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            errors++;
            $display("FAIL R9 watchdog actual %0d expected below %0d", wd, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int prev;
        // sweep every ordered pair of instruction shapes, then drain with a plain one
        for (int a = 0; a < 20; a++) begin
            for (int b = 0; b < 20; b++) begin
                do_reset();
                for (int s = 0; s < 2; s++) begin
                    int c;
                    int rv;
                    c  = (s == 0) ? a : b;
                    rv = 16'h1000 + a*16 + b + s;
                    if (c < 18)
                        send(c % 3, (c / 3) % 3, c / 9, 0, 0, rv, 16'h7F80, 0);
                    else
                        send(0, 0, 0, 1, c - 18, rv, 0, 16'h0200 + 4*b);
                end
                send(1, 0, 0, 0, 0, 0, 0, 0);
                drain();
                // R5: pending update is gone after the draining instruction
                chk(rd == wr, "R5 all updates issued", rd, wr);
            end
        end

        // R10: loop of indexed clear, autoincrement clear, immediate test, taken branch
        do_reset();
        send(0, 0, 0, 1, 1, 0, 0, 16'h0A34);
        send(1, 0, 0, 0, 0, 0, 0, 0);
        send(0, 0, 0, 0, 0, 0, 0, 0);
        drain();
        prev = clk_total;
        chk(prev == 16 + 20 + 8, "R10 loop preamble", prev, 44);
        for (int it = 0; it < 4; it++) begin
            int r;
            r = 16'h0081 + it;
            send(1, 1, 1, 0, 0, r, 16'h7F80, 0);
            send(0, 2, 1, 0, 0, r, 0, 0);
            send(1, 0, 0, 0, 0, 0, 0, 0);
            send(0, 0, 0, 1, 1, 0, 0, 16'h0A3A);
            drain();
            chk(clk_total - prev == 98, "R10 loop iteration", clk_total - prev, 98);
            prev = clk_total;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule